// File: doc/BRIEF.md
# Interrupt Mask Duration Monitor

This block watches the two interrupt mask bits of a processor core: the mask for ordinary interrupts and the mask for the non-maskable request. Each bit has its own channel, timed against one shared free-running cycle counter. A channel measures every stretch of cycles during which its mask bit stays set. For each channel it keeps three completed-interval lengths: the shortest, the longest and the most recent. It also reports the running length of an interval that has not yet ended.

Software or a debug agent reads these figures through a small request/response read port. A request carries an address and is accepted on a cycle where `req_valid` and `req_ready` are both high. One cycle later the matching response is presented with `resp_valid`. That response stays unchanged until the consumer takes it on a cycle with `resp_ready` high. `req_ready` is high whenever no response is held, or when the held response is taken in the same cycle, so a stalled consumer also stalls new requests. There is at most one response outstanding, and responses come back in request order.

Reading the longest length while an interval is still open has a side effect: the running length is folded into the stored longest value. The shortest value starts at an all-ones marker meaning "nothing recorded yet". While it still holds that marker, a read of the shortest value returns the longest value instead.

Top module: `mask_dur_mon`

## Requirements
- R1: After reset both open flags are low, no response is held, and every one of the eight addresses reads 0.
- R2: A channel's interval opens at the first clock edge that samples its mask bit high and closes at the first edge that samples it low. Its open flag is high from the cycle after the opening edge until the closing edge. The recorded length is the number of edges that sampled the bit high.
- R3: When an interval closes, the most recent length takes its value. The shortest length takes it if it is smaller than the stored one, and the longest length takes it if it is larger than the stored one.
- R4: The shortest-length register resets to all ones. While it still holds all ones, a read of the shortest length returns the stored longest length.
- R5: A read of the longest length while an interval is open returns the larger of the stored longest length and the running length. That larger value is then written back as the stored longest length.
- R6: Address bits [1:0] select the figure: 0 shortest, 1 longest, 2 most recent, 3 running length. The running length reads 0 when no interval is open. Address bit 2 selects the channel: 0 for the ordinary mask, 1 for the non-maskable mask.
- R7: The two channels are independent. Mask activity or reads on one channel never change the figures or the open flag of the other.
- R8: The cycle counter counts up from 0 after reset and stops at all ones. Lengths measured after it stops are 0 and never wrap.
- R9: A request is accepted exactly when `req_valid` and `req_ready` are both high, and it produces exactly one response on the next cycle. `req_ready` is low while a response is held and not being taken. A held response keeps `resp_valid` and `resp_data` stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mask_i | input | 1 | Ordinary interrupt mask bit, sampled each edge |
| mask_x | input | 1 | Non-maskable interrupt mask bit, sampled each edge |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Read request can be accepted this cycle |
| req_addr | input | 3 | Read address: bit 2 channel, bits 1:0 figure |
| resp_valid | output | 1 | Response data present |
| resp_ready | input | 1 | Consumer takes the response this cycle |
| resp_data | output | CNT_W (32) | Selected length in cycles |
| open_i | output | 1 | An ordinary-mask interval is open |
| open_x | output | 1 | A non-maskable-mask interval is open |

## Verification
The assertions assume the mask bits are synchronous to `clk` and hold their value across each edge. They also assume `resp_ready` and `req_valid` are driven only by the consumer, and that a pending request is never withdrawn while `req_ready` is low. The stimulus changes every input half a cycle away from the sampling edge. It keeps `req_valid` high until the bench sees `req_ready` high before an edge. It randomises `resp_ready` only in dedicated stall phases, so back-pressure is exercised without breaking the handshake rules. The bench uses a reduced counter width so that counter saturation is reached within the run.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  // Figure selected by the low two address bits.
  typedef enum logic [1:0] {
    SEL_SHORT = 2'd0,
    SEL_LONG  = 2'd1,
    SEL_LAST  = 2'd2,
    SEL_OPEN  = 2'd3
  } stat_sel_e;

  // Number of address bits needed to reach every figure of every channel.
  function automatic int addr_bits(input int nch);
    return ((nch > 1) ? $clog2(nch) : 1) + 2;
  endfunction

endpackage

// File: rtl/mdm_cycle_ctr.sv
module mdm_cycle_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] now
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign now = cnt_q;

endmodule

// File: rtl/mdm_channel.sv
module mdm_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask,
  input  logic [W-1:0] now,
  input  logic         fold_max,
  output logic         is_open,
  output logic [W-1:0] min_len,
  output logic [W-1:0] max_len,
  output logic [W-1:0] last_len,
  output logic [W-1:0] open_len
);

  // All-ones doubles as "no start latched" and "no minimum recorded".
  localparam logic [W-1:0] MARK = {W{1'b1}};

  logic         open_q;
  logic [W-1:0] start_q;
  logic [W-1:0] min_q;
  logic [W-1:0] max_q;
  logic [W-1:0] last_q;
  logic [W-1:0] span;
  logic [W-1:0] max_d;
  logic         opening;
  logic         closing;

  // The counter saturates, so now never falls below a latched start.
  assign span    = now - start_q;
  assign opening = mask & ~open_q;
  assign closing = ~mask & open_q;

  always_comb begin
    max_d = max_q;
    if (fold_max && open_q && (span > max_d)) max_d = span;
    if (closing && (span > max_d))            max_d = span;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      start_q <= MARK;
      min_q   <= MARK;
      max_q   <= '0;
      last_q  <= '0;
    end else begin
      max_q <= max_d;
      if (opening) begin
        open_q  <= 1'b1;
        start_q <= now;
      end else if (closing) begin
        open_q  <= 1'b0;
        start_q <= MARK;
        last_q  <= span;
        if (span < min_q) min_q <= span;
      end
    end
  end

  assign is_open  = open_q;
  assign min_len  = min_q;
  assign max_len  = max_q;
  assign last_len = last_q;
  assign open_len = open_q ? span : '0;

endmodule

// File: rtl/mdm_read_port.sv
module mdm_read_port
  import mdm_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [addr_bits(NCH)-1:0] req_addr,
  output logic                    resp_valid,
  input  logic                    resp_ready,
  output logic [W-1:0]            resp_data,
  input  logic [NCH-1:0]          open_v,
  input  logic [NCH-1:0][W-1:0]   min_v,
  input  logic [NCH-1:0][W-1:0]   max_v,
  input  logic [NCH-1:0][W-1:0]   last_v,
  input  logic [NCH-1:0][W-1:0]   cur_v,
  output logic [NCH-1:0]          fold_max
);

  localparam int AW = addr_bits(NCH);
  localparam int CW = AW - 2;
  localparam logic [W-1:0] MARK = {W{1'b1}};

  logic          valid_q;
  logic [W-1:0]  data_q;
  logic          accept;
  logic [CW-1:0] ch;
  stat_sel_e     sel;
  logic [W-1:0]  pick;

  assign req_ready = ~valid_q | resp_ready;
  assign accept    = req_valid & req_ready;
  assign ch        = req_addr[AW-1:2];
  assign sel       = stat_sel_e'(req_addr[1:0]);

  always_comb begin
    pick     = '0;
    fold_max = '0;
    unique case (sel)
      SEL_SHORT: pick = (min_v[ch] == MARK) ? max_v[ch] : min_v[ch];
      SEL_LONG: begin
        pick = (open_v[ch] && (cur_v[ch] > max_v[ch])) ? cur_v[ch] : max_v[ch];
        fold_max[ch] = accept;
      end
      SEL_LAST: pick = last_v[ch];
      default:  pick = cur_v[ch];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      data_q  <= pick;
    end else if (resp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign resp_valid = valid_q;
  assign resp_data  = data_q;

endmodule

// File: rtl/mask_dur_mon.sv
module mask_dur_mon
  import mdm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_i,
  input  logic             mask_x,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_addr,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [CNT_W-1:0] resp_data,
  output logic             open_i,
  output logic             open_x
);

  localparam int NCH = 2;

  logic [CNT_W-1:0]          now_cnt;
  logic [NCH-1:0]            mask_vec;
  logic [NCH-1:0]            open_vec;
  logic [NCH-1:0]            fold_vec;
  logic [NCH-1:0][CNT_W-1:0] min_vec;
  logic [NCH-1:0][CNT_W-1:0] max_vec;
  logic [NCH-1:0][CNT_W-1:0] last_vec;
  logic [NCH-1:0][CNT_W-1:0] cur_vec;

  assign mask_vec = {mask_x, mask_i};

  mdm_cycle_ctr #(.W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .now   (now_cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    mdm_channel #(.W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask     (mask_vec[c]),
      .now      (now_cnt),
      .fold_max (fold_vec[c]),
      .is_open  (open_vec[c]),
      .min_len  (min_vec[c]),
      .max_len  (max_vec[c]),
      .last_len (last_vec[c]),
      .open_len (cur_vec[c])
    );
  end

  mdm_read_port #(.W(CNT_W), .NCH(NCH)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_data  (resp_data),
    .open_v     (open_vec),
    .min_v      (min_vec),
    .max_v      (max_vec),
    .last_v     (last_vec),
    .cur_v      (cur_vec),
    .fold_max   (fold_vec)
  );

  assign open_i = open_vec[0];
  assign open_x = open_vec[1];

endmodule

// File: rtl/mdm_chk.sv
module mdm_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mask_i,
  input logic         mask_x,
  input logic         open_i,
  input logic         open_x,
  input logic         req_valid,
  input logic         req_ready,
  input logic         resp_valid,
  input logic         resp_ready,
  input logic [W-1:0] resp_data,
  input logic [W-1:0] now_cnt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  // R2: an interval opens on the first high sample of the mask
  p_open_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_i && mask_i) |=> open_i);

  // R2: an interval stays open while the mask remains high
  p_open_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (open_i && mask_i) |=> open_i);

  // R2: an interval closes on the first low sample of the mask
  p_open_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (open_i && !mask_i) |=> !open_i);

  // R7: the second channel follows its own mask only
  p_open_set_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_x && mask_x) |=> open_x);

  p_open_clr_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (open_x && !mask_x) |=> !open_x);

  // R8: the counter advances by one until it reaches all ones
  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (now_cnt != TOP) |=> ((now_cnt - $past(now_cnt)) == W'(1)));

  // R8: the counter stays at all ones once there
  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (now_cnt == TOP) |=> (now_cnt == TOP));

  // R9: an accepted request yields a response on the next cycle
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);

  // R9: a held response is not altered before it is taken
  p_resp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

  // R9: without a pending request or a held response, nothing appears
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!resp_valid && !req_valid) |=> !resp_valid);

endmodule

bind mask_dur_mon mdm_chk #(.W(CNT_W)) u_mdm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mask_i     (mask_i),
  .mask_x     (mask_x),
  .open_i     (open_i),
  .open_x     (open_x),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_data  (resp_data),
  .now_cnt    (now_cnt)
);

// File: tb/test_mask_dur_mon.sv
module test_mask_dur_mon;

  localparam int W    = 10;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mask_i = 1'b0;
  logic         mask_x = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [2:0]   req_addr = 3'd0;
  logic         resp_valid;
  logic         resp_ready = 1'b1;
  logic [W-1:0] resp_data;
  logic         open_i;
  logic         open_x;

  always #2 clk = ~clk;

  mask_dur_mon #(.CNT_W(W)) i_mask_dur_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_i     (mask_i),
    .mask_x     (mask_x),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_data  (resp_data),
    .open_i     (open_i),
    .open_x     (open_x)
  );

  int    total = 0;
  int    bad   = 0;
  bit    stall = 1'b0;
  string force_tag = "";

  typedef struct {
    int    val;
    int    addr;
    string tag;
  } item_t;
  item_t sb[$];

  // Reference state built from the requirements.
  int mcnt;
  int mstart [2];
  bit mopen  [2];
  int mmin   [2];
  int mmax   [2];
  int mlast  [2];

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    mcnt = 0;
    for (int c = 0; c < 2; c++) begin
      mopen[c] = 1'b0; mstart[c] = 0;
      mmin[c] = MAXV; mmax[c] = 0; mlast[c] = 0;
    end
  endtask

  // Consumer back-pressure: random only in stall phases.
  always @(negedge clk) resp_ready <= stall ? ($urandom_range(0, 2) == 0) : 1'b1;

  // Reference and monitor: sample just before each rising edge.
  initial begin
    model_reset();
    forever begin
      @(negedge clk);
      #1;
      if (!rst_n) begin
        model_reset();
        sb.delete();
      end else begin
        bit m [2];
        m[0] = mask_i;
        m[1] = mask_x;
        check("R2", "open_i", int'(open_i), int'(mopen[0]));
        check("R7", "open_x", int'(open_x), int'(mopen[1]));
        check("R9", "resp_valid", int'(resp_valid), int'(sb.size() != 0));
        if (resp_valid && resp_ready && sb.size() > 0) begin
          item_t it;
          it = sb.pop_front();
          check(it.tag, $sformatf("addr %0d", it.addr), int'(resp_data), it.val);
        end
        if (req_valid && req_ready) begin
          item_t it;
          int c, s, cur;
          c   = int'(req_addr[2]);
          s   = int'(req_addr[1:0]);
          cur = mopen[c] ? (mcnt - mstart[c]) : 0;
          it.addr = int'(req_addr);
          case (s)
            0: begin it.val = (mmin[c] == MAXV) ? mmax[c] : mmin[c];
                     it.tag = (mmin[c] == MAXV) ? "R4" : "R3"; end
            1: begin it.val = (mopen[c] && cur > mmax[c]) ? cur : mmax[c];
                     it.tag = mopen[c] ? "R5" : "R3";
                     mmax[c] = it.val; end
            2: begin it.val = mlast[c]; it.tag = "R3"; end
            default: begin it.val = cur; it.tag = "R2"; end
          endcase
          it.tag = (c == 1) ? {"R6/R7/", it.tag} : {"R6/", it.tag};
          if (force_tag != "") it.tag = force_tag;
          sb.push_back(it);
        end
        for (int c = 0; c < 2; c++) begin
          if (!mopen[c] && m[c]) begin
            mopen[c] = 1'b1; mstart[c] = mcnt;
          end else if (mopen[c] && !m[c]) begin
            int len;
            len = mcnt - mstart[c];
            mopen[c] = 1'b0;
            mlast[c] = len;
            if (len < mmin[c]) mmin[c] = len;
            if (len > mmax[c]) mmax[c] = len;
          end
        end
        if (mcnt < MAXV) mcnt++;
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_masks(input bit mi, input bit mx);
    @(negedge clk);
    mask_i = mi;
    mask_x = mx;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a[2:0];
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd_all();
    for (int a = 0; a < 8; a++) rd(a);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    hold(4);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1", "open_i after reset", int'(open_i), 0);
    check("R1", "open_x after reset", int'(open_x), 0);
    check("R1", "resp_valid after reset", int'(resp_valid), 0);
    force_tag = "R1";
    rd_all();
    force_tag = "";

    // R5/R4: fold an open interval into the longest value, then read shortest.
    set_masks(1, 0);
    hold(6);
    rd(1);
    rd(3);
    rd(0);
    set_masks(0, 0);
    hold(2);
    rd(0); rd(1); rd(2); rd(3);

    // R7: second channel alone.
    set_masks(0, 1);
    hold(3);
    set_masks(0, 0);
    hold(1);
    rd_all();

    // Overlapping intervals of different length on both channels.
    set_masks(1, 1);
    hold(4);
    set_masks(1, 0);
    hold(7);
    set_masks(0, 0);
    hold(1);
    rd_all();

    // R3: a one-cycle interval becomes the new shortest.
    set_masks(1, 0);
    set_masks(0, 0);
    hold(1);
    rd(0); rd(2);

    // R9: back-pressure with intervals and reads interleaved.
    stall = 1'b1;
    set_masks(0, 1);
    rd(5);
    rd(7);
    set_masks(1, 0);
    rd(3);
    rd(1);
    set_masks(0, 0);
    rd_all();
    rd_all();
    stall = 1'b0;
    hold(3);

    // R8: run the counter into saturation, then measure.
    hold(MAXV + 20);
    force_tag = "R8";
    set_masks(1, 1);
    hold(5);
    rd(3);
    rd(1);
    set_masks(0, 0);
    hold(1);
    rd(0); rd(2); rd(4); rd(6);
    force_tag = "";

    hold(5);
    check("R9", "responses left over", sb.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule